// File: doc/BRIEF.md
# I2C Register Access Master (24-bit address, 24-bit data)

This block is a byte-serial I2C bus master for a register file held in a remote device. Each register location is named by a 24-bit address: the top eight bits choose an internal address space, and the lower sixteen bits locate the register within it. Each register holds a 24-bit word. The host presents a 7-bit device address, the register address, the write word and a direction flag, then pulses a start request. The engine drives the open-drain clock and data lines, paced by a programmable quarter-period divider.

A write sends the device address with the direction bit clear, the three address bytes and the three data bytes, then releases the bus with a STOP. A read first sends the device address and the three address bytes without data. It then issues a repeated START and the device address with the direction bit set, and clocks in three bytes, most significant first. The master acknowledges the first two bytes and declines the third before the STOP. If the slave fails to acknowledge any byte the master sent, the engine stops the transfer and flags an error.

Top module: `i2c24_master`

## Requirements
- R1: After reset both bus lines are released (scl_oe=0, sda_oe=0), and busy, done, err and rdata are all 0.
- R2: Every slot (START, data bit, STOP) lasts four quarters of QDIV system clocks each. In a data bit SCL is low in quarters 0 and 3 and high in quarters 1 and 2, and the master samples SDA at the end of quarter 1.
- R3: A write (rw=0) sends, in order: START, byte {dev_addr,1'b0}, reg_addr[23:16], reg_addr[15:8], reg_addr[7:0], wdata[23:16], wdata[15:8], wdata[7:0], STOP. Each byte goes MSB first and is followed by a ninth clock with SDA released.
- R4: A read (rw=1) sends START, {dev_addr,1'b0} and the three address bytes, then a repeated START, then {dev_addr,1'b1}. It then clocks in three bytes; the first received bit becomes rdata[23] and the last becomes rdata[0].
- R5: On the ninth clock of the first two received bytes the master drives SDA low (ACK). On the ninth clock of the third it leaves SDA high (NACK), and the next slot is STOP.
- R6: Outside START and STOP slots, the master changes SDA only while SCL is low. A START lowers SDA while SCL is high and ends with SCL low. A STOP raises SDA while SCL is high. The first START of a transfer keeps SCL high in its first quarter, while a repeated START begins with SCL low.
- R7: If SDA is high at the sample point of the ninth clock of any master-sent byte, the next slot is STOP, no further byte is sent, and err reads 1 when done pulses. err is 0 at done when every byte was acknowledged.
- R8: A start pulse while busy=1 has no effect on the transfer in progress or on the bus afterwards.
- R9: busy is high from the cycle after an accepted start until the end of the STOP slot. In the first cycle after the STOP slot, busy is 0 and done is 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer request, accepted only when idle |
| rw | input | 1 | 1 = register read, 0 = register write |
| dev_addr | input | 7 | Seven-bit device address |
| reg_addr | input | 24 | Register address; [23:16] picks the address space |
| wdata | input | 24 | Word to write |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err | output | 1 | A master-sent byte was not acknowledged |
| rdata | output | 24 | Word received by the last read |

## Verification
The bench builds, quarter by quarter, the line levels and slave responses it expects. It compares both line drivers on every clock against writes and reads with differing address and data patterns. Some of these patterns have alternating bits and edge bytes, which separate MSB-first ordering and byte order from a reversed or shifted stream. Reads with mixed received bytes test the bit assembly into rdata and the ACK/ACK/NACK pattern. Slave refusals on a middle address byte, on the device address and on the read-direction address byte check that the abort is taken at the right byte, and a start pulse injected mid-transfer checks that the frame is not disturbed.

// File: rtl/i2c24_pkg.sv
package i2c24_pkg;

  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_START = 2'd1,
    SL_BIT   = 2'd2,
    SL_STOP  = 2'd3
  } slot_e;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 24;
  localparam int DEV_W  = 7;

  // Byte sent at position idx of the frame. Read frames reuse index 4 for
  // the device address with the direction bit set.
  function automatic logic [7:0] tx_byte(input logic [2:0] idx, input logic rd,
                                         input logic [DEV_W-1:0] dev,
                                         input logic [ADDR_W-1:0] addr,
                                         input logic [DATA_W-1:0] wd);
    logic [7:0] b;
    case (idx)
      3'd0:    b = {dev, 1'b0};
      3'd1:    b = addr[23:16];
      3'd2:    b = addr[15:8];
      3'd3:    b = addr[7:0];
      3'd4:    b = rd ? {dev, 1'b1} : wd[23:16];
      3'd5:    b = wd[15:8];
      default: b = wd[7:0];
    endcase
    return b;
  endfunction

  // Positions 5..7 of a read frame are received from the slave.
  function automatic logic is_rx(input logic [2:0] idx, input logic rd);
    return rd && (idx >= 3'd5);
  endfunction

  function automatic logic [2:0] last_idx(input logic rd);
    return rd ? 3'd7 : 3'd6;
  endfunction

endpackage

// File: rtl/i2c24_qtimer.sv
module i2c24_qtimer #(
  parameter int QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  output logic       tick,
  output logic [1:0] q
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] CMAX = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      q   <= 2'd0;
    end else if (!run) begin
      cnt <= '0;
      q   <= 2'd0;
    end else if (cnt == CMAX) begin
      cnt <= '0;
      q   <= q + 2'd1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == CMAX);

  // R2: a running quarter never stalls past its last count
  p_quarter_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run) |=> (q == $past(q) + 2'd1) || !run);

endmodule

// File: rtl/i2c24_linedrv.sv
module i2c24_linedrv
  import i2c24_pkg::*;
(
  input  slot_e      slot,
  input  logic [1:0] q,
  input  logic       rep,
  input  logic       bit_lvl,
  output logic       scl_lvl,
  output logic       sda_lvl
);
  always_comb begin
    unique case (slot)
      SL_START: begin
        scl_lvl = (q == 2'd0) ? !rep : (q != 2'd3);
        sda_lvl = (q < 2'd2);
      end
      SL_BIT: begin
        scl_lvl = (q == 2'd1) || (q == 2'd2);
        sda_lvl = bit_lvl;
      end
      SL_STOP: begin
        scl_lvl = (q != 2'd0);
        sda_lvl = (q >= 2'd2);
      end
      default: begin
        scl_lvl = 1'b1;
        sda_lvl = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/i2c24_ctrl.sv
module i2c24_ctrl
  import i2c24_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rw,
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic [1:0]        q,
  input  logic              sda_i,
  output slot_e             slot,
  output logic              rep,
  output logic              bit_lvl,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);
  logic              rw_r;
  logic [DEV_W-1:0]  dev_r;
  logic [ADDR_W-1:0] addr_r;
  logic [DATA_W-1:0] wd_r;
  logic [2:0]        idx_r;
  logic [3:0]        bitn_r;
  logic              nack_r;

  // named internal events
  logic       sample_ev;
  logic       slot_end;
  logic       accept;
  logic       ack_slot;
  logic       rx_byte;
  logic [7:0] cur_byte;

  assign sample_ev = tick && (q == 2'd1);
  assign slot_end  = tick && (q == 2'd3);
  assign accept    = start && (slot == SL_IDLE);
  assign ack_slot  = (bitn_r == 4'd8);
  assign rx_byte   = is_rx(idx_r, rw_r);
  assign cur_byte  = tx_byte(idx_r, rw_r, dev_r, addr_r, wd_r);
  assign busy      = (slot != SL_IDLE);

  always_comb begin
    if (!ack_slot)
      bit_lvl = rx_byte ? 1'b1 : cur_byte[3'd7 - bitn_r[2:0]];
    else
      bit_lvl = rx_byte ? (idx_r == 3'd7) : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= SL_IDLE;
      rep    <= 1'b0;
      rw_r   <= 1'b0;
      dev_r  <= '0;
      addr_r <= '0;
      wd_r   <= '0;
      idx_r  <= 3'd0;
      bitn_r <= 4'd0;
      nack_r <= 1'b0;
      err    <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        slot   <= SL_START;
        rep    <= 1'b0;
        rw_r   <= rw;
        dev_r  <= dev_addr;
        addr_r <= reg_addr;
        wd_r   <= wdata;
        idx_r  <= 3'd0;
        bitn_r <= 4'd0;
        nack_r <= 1'b0;
        err    <= 1'b0;
        rdata  <= '0;
      end else begin
        if (sample_ev && (slot == SL_BIT)) begin
          if (rx_byte && !ack_slot)
            rdata <= {rdata[DATA_W-2:0], sda_i};
          if (!rx_byte && ack_slot && sda_i) begin
            nack_r <= 1'b1;
            err    <= 1'b1;
          end
        end
        if (slot_end) begin
          unique case (slot)
            SL_START: begin
              slot   <= SL_BIT;
              bitn_r <= 4'd0;
            end
            SL_BIT: begin
              if (!ack_slot) begin
                bitn_r <= bitn_r + 4'd1;
              end else begin
                bitn_r <= 4'd0;
                if (nack_r || (idx_r == last_idx(rw_r))) begin
                  slot <= SL_STOP;
                end else if (rw_r && (idx_r == 3'd3)) begin
                  slot  <= SL_START;
                  rep   <= 1'b1;
                  idx_r <= 3'd4;
                end else begin
                  idx_r <= idx_r + 3'd1;
                end
              end
            end
            SL_STOP: begin
              slot <= SL_IDLE;
              done <= 1'b1;
            end
            default: slot <= SL_IDLE;
          endcase
        end
      end
    end
  end

  // R7: a refused byte leads straight into the STOP slot
  p_nack_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && (slot == SL_BIT) && ack_slot && nack_r) |=> (slot == SL_STOP));

  // R8: a request during a transfer leaves the latched frame untouched
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(addr_r) && $stable(rw_r) && $stable(wd_r) && $stable(dev_r)));

  // R9: done lasts exactly one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done only follows the STOP slot
  p_done_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(slot) == SL_STOP) && !busy);

endmodule

// File: rtl/i2c24_master.sv
module i2c24_master
  import i2c24_pkg::*;
#(
  parameter int QDIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rw,
  input  logic [6:0]  dev_addr,
  input  logic [23:0] reg_addr,
  input  logic [23:0] wdata,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [23:0] rdata
);
  slot_e      slot;
  logic       rep;
  logic       bit_lvl;
  logic       tick;
  logic [1:0] q;
  logic       scl_lvl;
  logic       sda_lvl;
  logic       run;

  assign run = (slot != SL_IDLE);

  i2c24_qtimer #(.QDIV(QDIV)) u_qtimer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick),
    .q     (q)
  );

  i2c24_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rw       (rw),
    .dev_addr (dev_addr),
    .reg_addr (reg_addr),
    .wdata    (wdata),
    .tick     (tick),
    .q        (q),
    .sda_i    (sda_i),
    .slot     (slot),
    .rep      (rep),
    .bit_lvl  (bit_lvl),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .rdata    (rdata)
  );

  i2c24_linedrv u_linedrv (
    .slot    (slot),
    .q       (q),
    .rep     (rep),
    .bit_lvl (bit_lvl),
    .scl_lvl (scl_lvl),
    .sda_lvl (sda_lvl)
  );

  assign scl_oe = !scl_lvl;
  assign sda_oe = !sda_lvl;

  // R6: with SCL held high, SDA may move only inside START or STOP
  p_sda_moves_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl) && (sda_lvl != $past(sda_lvl)))
      |-> ((slot == SL_START) || (slot == SL_STOP)));

  // R2: the sample point always falls inside SCL high
  p_sample_scl_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (q == 2'd1) && (slot == SL_BIT)) |-> scl_lvl);

  // R1: an idle engine releases both lines
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/i2c24_master_bench.sv
module i2c24_master_bench;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rw = 1'b0;
  logic [6:0]  dev_addr = '0;
  logic [23:0] reg_addr = '0;
  logic [23:0] wdata = '0;
  logic        pull = 1'b0;
  logic        sda_i;
  logic        scl_oe, sda_oe, busy, done, err;
  logic [23:0] rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int eq[$];
  bit exp_err;

  assign sda_i = !(sda_oe | pull);

  always #5 clk = ~clk;

  i2c24_master #(.QDIV(DIV)) u_i2c24_master (
    .clk(clk), .rst_n(rst_n), .start(start), .rw(rw), .dev_addr(dev_addr),
    .reg_addr(reg_addr), .wdata(wdata), .sda_i(sda_i), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .busy(busy), .done(done), .err(err), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one quarter: SCL level, master SDA level, slave pull-down
  task automatic addq(input int s, input int d, input int p);
    eq.push_back(s * 4 + d * 2 + p);
  endtask

  task automatic add_bit(input int d, input int p);
    addq(0, d, p); addq(1, d, p); addq(1, d, p); addq(0, d, p);
  endtask

  task automatic add_start(input bit again);
    addq(again ? 0 : 1, 1, 0); addq(1, 1, 0); addq(1, 0, 0); addq(0, 0, 0);
  endtask

  task automatic add_stop();
    addq(0, 0, 0); addq(1, 0, 0); addq(1, 1, 0); addq(1, 1, 0);
  endtask

  task automatic add_tx(input logic [7:0] b, input bit slave_ack);
    for (int i = 7; i >= 0; i--) add_bit(b[i], 0);
    add_bit(1, slave_ack);
  endtask

  task automatic add_rx(input logic [7:0] b, input bit master_ack);
    for (int i = 7; i >= 0; i--) add_bit(1, !b[i]);
    add_bit(master_ack ? 0 : 1, 0);
  endtask

  task automatic run_txn(input bit rd, input logic [6:0] dev, input logic [23:0] a,
                         input logic [23:0] w, input logic [23:0] sd,
                         input int nack_at, input bit inject);
    logic [7:0] txb [0:6];
    bit stopped;
    int last;
    int n;
    string req;
    txb[0] = {dev, 1'b0};
    txb[1] = a[23:16];
    txb[2] = a[15:8];
    txb[3] = a[7:0];
    txb[4] = rd ? {dev, 1'b1} : w[23:16];
    txb[5] = w[15:8];
    txb[6] = w[7:0];
    eq.delete();
    exp_err = 0;
    stopped = 0;
    last = rd ? 4 : 6;
    add_start(0);
    for (int i = 0; i <= last; i++) begin
      if (!stopped) begin
        if (rd && i == 4) add_start(1);
        add_tx(txb[i], i != nack_at);
        if (i == nack_at) begin
          stopped = 1;
          exp_err = 1;
        end
      end
    end
    if (rd && !stopped) begin
      add_rx(sd[23:16], 1);
      add_rx(sd[15:8], 1);
      add_rx(sd[7:0], 0);
    end
    add_stop();
    req = rd ? "R4 R2 R5 R6 R8 lines" : "R3 R2 R6 R8 lines";

    @(negedge clk);
    rw = rd; dev_addr = dev; reg_addr = a; wdata = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = eq.size() * DIV;
    for (int c = 0; c < n; c++) begin
      int e;
      e = eq[c / DIV];
      pull = e[0];
      chk(scl_oe == !e[2], req, scl_oe, !e[2]);
      chk(sda_oe == !e[1], req, sda_oe, !e[1]);
      chk(busy == 1'b1, "R9 busy", busy, 1);
      if (inject && c == 20) begin
        start = 1'b1; reg_addr = ~a; rw = ~rd; dev_addr = ~dev;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    pull = 1'b0;
    chk(done == 1'b1, "R9 done", done, 1);
    chk(busy == 1'b0, "R9 busy end", busy, 0);
    chk(err == exp_err, "R7 err", err, exp_err);
    if (rd && !exp_err) chk(rdata == sd, "R4 rdata", rdata, sd);
    @(negedge clk);
    chk(done == 1'b0, "R9 one-cycle done", done, 0);
    chk(busy == 1'b0, "R8 no late start", busy, 0);
    chk(!scl_oe && !sda_oe, "R6 bus released", {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);
    chk(!busy && !done && !err, "R1 flags", {busy, done, err}, 0);
    chk(rdata == 24'h0, "R1 rdata", rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy, "R1 after release", {scl_oe, sda_oe, busy}, 0);

    // R3: plain write
    run_txn(0, 7'h5A, 24'h12A5F0, 24'hC30F81, 24'h0, -1, 0);
    // R4 R5: read with mixed bytes
    run_txn(1, 7'h2C, 24'h0310FF, 24'h0, 24'hA53C96, -1, 0);
    // R7: slave refuses middle address byte
    run_txn(0, 7'h11, 24'h80FE01, 24'h123456, 24'h0, 2, 0);
    // R7 R8: slave refuses the read-direction address byte; start injected
    run_txn(1, 7'h7F, 24'h00AA55, 24'h0, 24'hFFFFFF, 4, 1);
    // R7: device address refused
    run_txn(1, 7'h01, 24'hFFFFFF, 24'h0, 24'h0, 0, 0);
    // R4 R8: read of edge pattern with a start injected mid-frame
    run_txn(1, 7'h40, 24'hFF0001, 24'h0, 24'h000001, -1, 1);
    // R3: all-ones write
    run_txn(0, 7'h7F, 24'hFFFFFF, 24'hFFFFFF, 24'h0, -1, 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule